// File: doc/BRIEF.md
# Double-Width Iterative Divider with Overflow Fault

This block divides a 2W-bit dividend by a W-bit divisor, either as unsigned numbers or as two's-complement signed numbers. The dividend arrives as two W-bit words, an upper word and a lower word, placed one above the other. A successful operation returns a W-bit quotient, which the surrounding datapath writes back into the lower-word register, and a W-bit remainder, which goes back into the upper-word register. Signed division truncates toward zero. The remainder carries the sign of the dividend, and the quotient is negative when the two operand signs differ.

The operation does not produce a result when it cannot be represented. That happens when the divisor is zero, when the quotient needs more than W bits, or, in signed mode, when the dividend is the most negative 2W-bit value or the quotient falls outside the signed W-bit range. In each of these cases the block reports a divide-error fault and keeps its previous outputs. Cheap checks made when the operands are accepted catch most overflow cases in the first cycle. Only the signed-range check waits for the iterative magnitude divider to finish. The divider retires BPC quotient bits per clock.

A caller pulses `start` while the block is idle. It then waits for the one-cycle `done` pulse and reads `fault`, `quotient` and `remainder` in that cycle.

Top module: `wide_divider`

## Requirements
- R1: Unsigned mode (`signed_mode`=0) with `dividend_hi` < `divisor`: `quotient` = floor({hi,lo}/divisor) and `remainder` = {hi,lo} mod divisor, presented together with `done`=1 and `fault`=0.
- R2: A zero divisor, in either mode, gives `done`=1 and `fault`=1 on the first rising edge after the edge that accepts `start`, and leaves `quotient` and `remainder` unchanged.
- R3: In unsigned mode, `dividend_hi` >= `divisor` (the quotient needs more than W bits) gives a fault on the first edge after acceptance, with outputs unchanged.
- R4: In signed mode, a dividend whose upper word is 1 followed by W-1 zeros and whose lower word is zero gives a fault on the first edge after acceptance.
- R5: Signed mode truncates toward zero. The remainder has the sign of the dividend (or is zero), and the quotient is negated when the operand signs differ (for example, -7/2 gives -3 remainder -1, and 7/-2 gives -3 remainder 1).
- R6: In signed mode, a quotient outside [-2^(W-1), 2^(W-1)-1] is a fault. A quotient of exactly -2^(W-1) is a valid result.
- R7: Latency: an operation that passes the acceptance checks signals `done` on the (STEPS+1)th rising edge after the accepting edge, where STEPS = W/BPC. This holds for the late signed-range fault too. `busy` is high from the accepting edge until `done` rises.
- R8: `done` is a one-cycle pulse, and `fault` is high only together with `done`.
- R9: A `start` that arrives while `busy` is high is ignored and does not disturb the running operation.
- R10: A `start` presented in the cycle where `done` is high is accepted, so operations can run back to back.
- R11: After reset, `busy`, `done` and `fault` are 0 and `quotient` and `remainder` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request a division; accepted only while idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend_hi | input | W | Upper word of the dividend |
| dividend_lo | input | W | Lower word of the dividend |
| divisor | input | W | Divisor |
| busy | output | 1 | An accepted operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Divide error; valid with done |
| quotient | output | W | Quotient of the last successful operation |
| remainder | output | W | Remainder of the last successful operation |

## Verification
Two events can fall in the same cycle: delivering a completion with `done` and accepting a new `start`. The bench drives the next request in exactly the cycle where `done` is high, including a request that faults early. A cycle-by-cycle reference model then judges it: the new operation must be accepted, `busy` must rise, and the previous results must stay visible until the new completion. A second collision is a `start` held high while the divider is busy. The model expects that request to be dropped, and the bench compares every output on every clock.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } wdiv_state_e;

endpackage

// File: rtl/wdiv_prep.sv
// Operand conditioning: magnitudes, signs and the checks that can be made
// before any iteration.
module wdiv_prep #(
  parameter int W = 64
) (
  input  logic         sgn_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] dsr_i,
  output logic [W-1:0] mag_hi_o,
  output logic [W-1:0] mag_lo_o,
  output logic [W-1:0] mag_d_o,
  output logic         n_neg_o,
  output logic         d_neg_o,
  output logic         early_fault_o
);

  localparam logic [W-1:0] MIN_WORD = {1'b1, {(W-1){1'b0}}};

  logic [2*W-1:0] n_full;
  logic [2*W-1:0] n_mag;
  logic           dz;
  logic           min_dvd;
  logic           too_big;

  always_comb begin
    n_neg_o  = sgn_i & hi_i[W-1];
    d_neg_o  = sgn_i & dsr_i[W-1];
    n_full   = {hi_i, lo_i};
    n_mag    = n_neg_o ? (~n_full + 1'b1) : n_full;
    mag_hi_o = n_mag[2*W-1:W];
    mag_lo_o = n_mag[W-1:0];
    mag_d_o  = d_neg_o ? (~dsr_i + 1'b1) : dsr_i;
    dz       = (dsr_i == '0);
    min_dvd  = sgn_i & (hi_i == MIN_WORD) & (lo_i == '0);
    // quotient magnitude reaches 2^W whenever upper magnitude >= divisor magnitude
    too_big  = (mag_hi_o >= mag_d_o);
    early_fault_o = dz | min_dvd | too_big;
  end

endmodule

// File: rtl/wdiv_step.sv
// One restoring-division step: shift one dividend bit in, trial-subtract.
module wdiv_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dsr_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);

  logic [W:0]   trial;
  logic [W-1:0] diff;
  logic         fits;

  always_comb begin
    trial = {rem_i, quo_i[W-1]};
    fits  = (trial >= {1'b0, dsr_i});
    // true difference is below the divisor, so W bits hold it exactly
    diff  = trial[W-1:0] - dsr_i;
    rem_o = fits ? diff : trial[W-1:0];
    quo_o = {quo_i[W-2:0], fits};
  end

endmodule

// File: rtl/wdiv_post.sv
// Sign restoration and the signed-range check on the finished magnitudes.
module wdiv_post #(
  parameter int W = 64
) (
  input  logic         sgn_i,
  input  logic         n_neg_i,
  input  logic         d_neg_i,
  input  logic [W-1:0] q_mag_i,
  input  logic [W-1:0] r_mag_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         late_fault_o
);

  localparam logic [W-1:0] MIN_WORD = {1'b1, {(W-1){1'b0}}};

  logic q_neg;

  always_comb begin
    q_neg        = n_neg_i ^ d_neg_i;
    quo_o        = q_neg   ? (~q_mag_i + 1'b1) : q_mag_i;
    rem_o        = n_neg_i ? (~r_mag_i + 1'b1) : r_mag_i;
    late_fault_o = sgn_i & (q_neg ? (q_mag_i > MIN_WORD) : q_mag_i[W-1]);
  end

endmodule

// File: rtl/wide_divider.sv
module wide_divider #(
  parameter int W   = 64,
  parameter int BPC = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] dividend_hi,
  input  logic [W-1:0] dividend_lo,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         fault,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  import wdiv_pkg::*;

  localparam int STEPS = W / BPC;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // operand conditioning
  logic [W-1:0] pre_hi, pre_lo, pre_d;
  logic         pre_nneg, pre_dneg, pre_fault;

  wdiv_prep #(.W(W)) u_prep (
    .sgn_i         (signed_mode),
    .hi_i          (dividend_hi),
    .lo_i          (dividend_lo),
    .dsr_i         (divisor),
    .mag_hi_o      (pre_hi),
    .mag_lo_o      (pre_lo),
    .mag_d_o       (pre_d),
    .n_neg_o       (pre_nneg),
    .d_neg_o       (pre_dneg),
    .early_fault_o (pre_fault)
  );

  // state
  wdiv_state_e  state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] sh_q, sh_d;
  logic [W-1:0] dsr_q, dsr_d;
  logic         sgn_q, sgn_d;
  logic         nneg_q, nneg_d;
  logic         dneg_q, dneg_d;
  logic         done_q, done_d;
  logic         fault_q, fault_d;
  logic [W-1:0] quo_q, quo_d;
  logic [W-1:0] rem_q, rem_d;
  logic         op_en;
  logic         res_en;

  // iteration chain, BPC steps per clock
  logic [W-1:0] ch_r [BPC+1];
  logic [W-1:0] ch_q [BPC+1];

  assign ch_r[0] = acc_q;
  assign ch_q[0] = sh_q;

  for (genvar g = 0; g < BPC; g++) begin : g_step
    wdiv_step #(.W(W)) u_step (
      .rem_i (ch_r[g]),
      .quo_i (ch_q[g]),
      .dsr_i (dsr_q),
      .rem_o (ch_r[g+1]),
      .quo_o (ch_q[g+1])
    );
  end

  // sign restoration
  logic [W-1:0] post_q, post_r;
  logic         post_fault;

  wdiv_post #(.W(W)) u_post (
    .sgn_i        (sgn_q),
    .n_neg_i      (nneg_q),
    .d_neg_i      (dneg_q),
    .q_mag_i      (sh_q),
    .r_mag_i      (acc_q),
    .quo_o        (post_q),
    .rem_o        (post_r),
    .late_fault_o (post_fault)
  );

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    sh_d    = sh_q;
    dsr_d   = dsr_q;
    sgn_d   = sgn_q;
    nneg_d  = nneg_q;
    dneg_d  = dneg_q;
    done_d  = 1'b0;
    fault_d = 1'b0;
    quo_d   = quo_q;
    rem_d   = rem_q;
    op_en   = 1'b0;
    res_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (pre_fault) begin
            done_d  = 1'b1;
            fault_d = 1'b1;
          end else begin
            op_en   = 1'b1;
            state_d = ST_RUN;
            cnt_d   = '0;
            acc_d   = pre_hi;
            sh_d    = pre_lo;
            dsr_d   = pre_d;
            sgn_d   = signed_mode;
            nneg_d  = pre_nneg;
            dneg_d  = pre_dneg;
          end
        end
      end
      ST_RUN: begin
        op_en = 1'b1;
        acc_d = ch_r[BPC];
        sh_d  = ch_q[BPC];
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIN;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        if (post_fault) begin
          fault_d = 1'b1;
        end else begin
          res_en = 1'b1;
          quo_d  = post_q;
          rem_d  = post_r;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      fault_q <= fault_d;
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (op_en) begin
      acc_q  <= acc_d;
      sh_q   <= sh_d;
      dsr_q  <= dsr_d;
      sgn_q  <= sgn_d;
      nneg_q <= nneg_d;
      dneg_q <= dneg_d;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      quo_q <= '0;
      rem_q <= '0;
    end else if (res_en) begin
      quo_q <= quo_d;
      rem_q <= rem_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign fault     = fault_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;

endmodule

// File: rtl/wdiv_checker.sv
module wdiv_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         signed_mode,
  input logic [W-1:0] dividend_hi,
  input logic [W-1:0] dividend_lo,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic         fault,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);

  localparam logic [W-1:0] MIN_WORD = {1'b1, {(W-1){1'b0}}};

  // R8
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R2
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=> (done && fault));

  // R3
  uns_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !signed_mode && dividend_hi >= divisor) |=> (done && fault));

  // R4
  min_dividend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && signed_mode && dividend_hi == MIN_WORD && dividend_lo == '0)
    |=> (done && fault));

  // R2
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($stable(quotient) && $stable(remainder)));

  // R1
  result_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder)));

  // R9
  busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

bind wide_divider wdiv_checker #(.W(W)) u_wdiv_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .start       (start),
  .signed_mode (signed_mode),
  .dividend_hi (dividend_hi),
  .dividend_lo (dividend_lo),
  .divisor     (divisor),
  .busy        (busy),
  .done        (done),
  .fault       (fault),
  .quotient    (quotient),
  .remainder   (remainder)
);

// File: tb/test_wide_divider.sv
`timescale 1ns/1ps
module test_wide_divider;

  localparam int W = 64;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         signed_mode;
  logic [W-1:0] dividend_hi;
  logic [W-1:0] dividend_lo;
  logic [W-1:0] divisor;
  logic         busy;
  logic         done;
  logic         fault;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;

  wide_divider #(.W(W), .BPC(1)) i_wide_divider (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .signed_mode (signed_mode),
    .dividend_hi (dividend_hi),
    .dividend_lo (dividend_lo),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .fault       (fault),
    .quotient    (quotient),
    .remainder   (remainder)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R11";

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic         m_busy, m_done, m_fault;
  logic [W-1:0] m_q, m_r;
  int           m_cnt;
  logic         p_fault;
  logic [W-1:0] p_q, p_r;

  task automatic compute(input logic sg, input logic [W-1:0] h, input logic [W-1:0] l,
                         input logic [W-1:0] d, output logic early, output logic flt,
                         output logic [W-1:0] q, output logic [W-1:0] r);
    logic [2*W-1:0]        un, uq, absn;
    logic [W-1:0]          absd;
    logic signed [2*W-1:0] sn, sd, sq, sr, maxq, minq;
    q = '0; r = '0; flt = 1'b0; early = 1'b0;
    if (!sg) begin
      un = {h, l};
      if (d == '0 || h >= d) begin
        early = 1'b1; flt = 1'b1;
      end else begin
        uq = un / {{W{1'b0}}, d};
        q  = uq[W-1:0];
        uq = un % {{W{1'b0}}, d};
        r  = uq[W-1:0];
      end
    end else begin
      sn   = {h, l};
      sd   = {{W{d[W-1]}}, d};
      absn = (sn < 0) ? -sn : sn;
      absd = d[W-1] ? -d : d;
      if (d == '0 || (h == {1'b1, {(W-1){1'b0}}} && l == '0) || absn[2*W-1:W] >= absd) begin
        early = 1'b1; flt = 1'b1;
      end else begin
        sq   = sn / sd;
        sr   = sn % sd;
        maxq = (128'sd1 <<< (W-1)) - 128'sd1;
        minq = -(128'sd1 <<< (W-1));
        if (sq > maxq || sq < minq) flt = 1'b1;
        q = sq[W-1:0];
        r = sr[W-1:0];
      end
    end
  endtask

  always @(posedge clk) begin
    logic early;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_fault = 0; m_q = '0; m_r = '0; m_cnt = 0;
    end else begin
      m_done = 0; m_fault = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done  = 1; m_busy = 0; m_fault = p_fault;
          if (!p_fault) begin m_q = p_q; m_r = p_r; end
        end
      end else if (start) begin
        compute(signed_mode, dividend_hi, dividend_lo, divisor, early, p_fault, p_q, p_r);
        if (early) begin
          m_done = 1; m_fault = 1;
        end else begin
          m_busy = 1; m_cnt = W + 1;
        end
      end
    end
  end

  // every-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk({cur_req, " busy"}, W'(busy), W'(m_busy));
      chk({cur_req, " done"}, W'(done), W'(m_done));
      chk({cur_req, " fault"}, W'(fault), W'(m_fault));
      chk({cur_req, " quotient"}, quotient, m_q);
      chk({cur_req, " remainder"}, remainder, m_r);
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic         got_fault;
  logic [W-1:0] got_q, got_r;
  int           lat;

  task automatic run_op(input logic sg, input logic [W-1:0] h, input logic [W-1:0] l,
                        input logic [W-1:0] d);
    @(negedge clk);
    start = 1'b1; signed_mode = sg; dividend_hi = h; dividend_lo = l; divisor = d;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 400);
    got_fault = fault; got_q = quotient; got_r = remainder;
  endtask

  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] MINW = {1'b1, {(W-1){1'b0}}};

  initial begin
    logic [W-1:0] pq, pr;
    start = 0; signed_mode = 0; dividend_hi = '0; dividend_lo = '0; divisor = 1;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 busy", W'(busy), '0);
    chk("R11 done", W'(done), '0);
    chk("R11 fault", W'(fault), '0);
    chk("R11 quotient", quotient, '0);
    chk("R11 remainder", remainder, '0);

    // R1 basic unsigned
    cur_req = "R1";
    run_op(0, '0, 64'd100, 64'd7);
    chk("R1 fault", W'(got_fault), '0);
    chk("R1 quotient", got_q, 64'd14);
    chk("R1 remainder", got_r, 64'd2);
    // R7 latency of a full-length operation
    chk("R7 latency", W'(lat), W'(W + 2));

    // R1 / R3 boundary: largest quotient that fits
    run_op(0, ONES - 64'd1, ONES, ONES);
    chk("R1 max fault", W'(got_fault), '0);
    chk("R1 max quotient", got_q, ONES);
    chk("R1 max remainder", got_r, ONES - 64'd1);

    // R3 unsigned overflow at hi == divisor
    cur_req = "R3";
    pq = quotient; pr = remainder;
    run_op(0, 64'd3, 64'd0, 64'd3);
    chk("R3 fault", W'(got_fault), 64'd1);
    chk("R3 latency", W'(lat), 64'd1);
    chk("R3 quotient held", got_q, pq);
    chk("R3 remainder held", got_r, pr);

    // R2 zero divisor in both modes
    cur_req = "R2";
    run_op(0, '0, 64'd5, '0);
    chk("R2 unsigned fault", W'(got_fault), 64'd1);
    chk("R2 latency", W'(lat), 64'd1);
    chk("R2 quotient held", got_q, pq);
    run_op(1, ONES, ONES, '0);
    chk("R2 signed fault", W'(got_fault), 64'd1);
    chk("R2 remainder held", got_r, pr);

    // R5 signed truncation and remainder sign
    cur_req = "R5";
    run_op(1, ONES, -64'sd7, 64'd2);
    chk("R5 -7/2 q", got_q, -64'sd3);
    chk("R5 -7/2 r", got_r, -64'sd1);
    run_op(1, '0, 64'd7, -64'sd2);
    chk("R5 7/-2 q", got_q, -64'sd3);
    chk("R5 7/-2 r", got_r, 64'd1);
    run_op(1, ONES, -64'sd7, -64'sd2);
    chk("R5 -7/-2 q", got_q, 64'd3);
    chk("R5 -7/-2 r", got_r, -64'sd1);

    // R4 most negative dividend
    cur_req = "R4";
    pq = quotient;
    run_op(1, MINW, '0, 64'd5);
    chk("R4 fault", W'(got_fault), 64'd1);
    chk("R4 latency", W'(lat), 64'd1);
    chk("R4 quotient held", got_q, pq);

    // R6 signed range
    cur_req = "R6";
    run_op(1, '0, MINW, 64'd1);
    chk("R6 +2^63 fault", W'(got_fault), 64'd1);
    chk("R6 late fault latency R7", W'(lat), W'(W + 2));
    chk("R6 quotient held", got_q, pq);
    run_op(1, ONES, MINW, 64'd1);
    chk("R6 -2^63 valid", W'(got_fault), '0);
    chk("R6 -2^63 quotient", got_q, MINW);
    run_op(1, ONES, MINW, ONES);
    chk("R6 -2^63/-1 fault", W'(got_fault), 64'd1);

    // R9 start while busy is ignored
    cur_req = "R9";
    @(negedge clk);
    start = 1; signed_mode = 0; dividend_hi = '0; dividend_lo = 64'd100; divisor = 64'd7;
    @(negedge clk);
    dividend_lo = 64'd9; divisor = '0;
    repeat (3) @(negedge clk);
    start = 0;
    lat = 0;
    while (!done && lat < 400) begin @(negedge clk); lat++; end
    chk("R9 fault", W'(fault), '0);
    chk("R9 quotient", quotient, 64'd14);
    chk("R9 remainder", remainder, 64'd2);

    // R10 back to back: new start in the done cycle
    cur_req = "R10";
    run_op(0, '0, 64'd1000, 64'd10);
    chk("R10 first quotient", got_q, 64'd100);
    start = 1; signed_mode = 1; dividend_hi = ONES; dividend_lo = -64'sd9; divisor = 64'd4;
    @(negedge clk);
    start = 0;
    chk("R10 accepted busy", W'(busy), 64'd1);
    chk("R10 old result visible", quotient, 64'd100);
    lat = 0;
    while (!done && lat < 400) begin @(negedge clk); lat++; end
    chk("R10 second quotient", quotient, -64'sd2);
    chk("R10 second remainder", remainder, -64'sd1);
    // early fault arriving right in a done cycle
    start = 1; signed_mode = 0; dividend_hi = 64'd9; dividend_lo = '0; divisor = 64'd2;
    @(negedge clk);
    start = 0;
    chk("R10 early fault done", W'(done), 64'd1);
    chk("R10 early fault flag", W'(fault), 64'd1);

    // R8 and R1/R5 under mixed operands
    cur_req = "R8";
    for (int k = 0; k < 24; k++) begin
      logic [W-1:0] d, h, l;
      logic         sg;
      sg = k[0];
      d  = {$urandom(), $urandom()} >> (k % 40);
      l  = {$urandom(), $urandom()};
      h  = (k % 5 == 0) ? d : (d >> ((k % 3) + 1));
      if (sg && l[5]) h = ~h;
      run_op(sg, h, l, d);
      @(negedge clk);
      chk("R8 done pulse", W'(done), '0);
      chk("R8 fault only with done", W'(fault), '0);
    end

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule